// File: doc/BRIEF.md
# UART Receive Queue with Per-Character Error Tracking

This block sits between a UART receiver and the register interface that software reads. Each character the receiver delivers is queued together with three condition flags: line break, bad stop bit (framing) and parity mismatch. The flags stay attached to their character for as long as it is queued. The data read port returns the oldest character and removes it from the queue. A separate status read shows the flags of that same oldest character without removing it.

The status word also carries a summary flag. This flag is set while any queued character, at any position, carries a flag. It drops only when the last flagged character has been read out. A counter of flagged entries drives it, so its value never depends on scanning the storage. The queue also reports its fill level, full and empty, and an overrun that is held until the next status read.

Top module: `uart_rx_err_fifo`

## Requirements
- R1: After reset the queue is empty: `level_o` is 0, `empty_o` is 1, `full_o` is 0 and `stat_o` is 0x00.
- R2: Characters leave in the order they were accepted. `rd_data_o` shows the oldest character, and `level_o` follows each accepted push and each pop.
- R3: `stat_o` bit 4 is the break flag, bit 3 the framing flag and bit 2 the parity flag. All three belong to the oldest queued character and are 0 when the queue is empty.
- R4: A status read (`rd_stat_i`) never removes an entry. Level, head data and head flags stay the same afterwards.
- R5: `stat_o` bit 7 is 1 while at least one queued entry has any flag set. It returns to 0 in the cycle after the last such entry is popped, even if clean entries remain.
- R6: A push while full, with no pop in that cycle, drops the character and sets `stat_o` bit 1. Bit 1 stays set until the clock edge of a status read and is 0 from the following cycle.
- R7: A push and a pop in the same cycle are both performed. The level is unchanged, and bit 7 reflects the entry removed and the entry added.
- R8: A data read while empty returns 0x00 on `rd_data_o` and moves no pointer. The next character pushed is the next one read.
- R9: `stat_o` bit 0 equals "not empty". Bit 5 equals `full_o`, which is 1 exactly when the level equals the depth (16). Bit 6 is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Receiver delivers a character this cycle |
| wr_data_i | input | 8 | Received character |
| wr_brk_i | input | 1 | Break condition for this character |
| wr_frm_i | input | 1 | Framing error for this character |
| wr_par_i | input | 1 | Parity error for this character |
| rd_data_i | input | 1 | Data read: pop the head entry at this edge |
| rd_data_o | output | 8 | Head character, 0 when empty |
| rd_stat_i | input | 1 | Status read: clears the overrun flag at this edge |
| stat_o | output | 8 | Status word (bits per R3, R5, R6, R9) |
| full_o | output | 1 | Queue holds 16 entries |
| empty_o | output | 1 | Queue holds no entries |
| level_o | output | 5 | Number of queued entries |

## Verification
The hardest state to reach is the one where the summary flag must drop while clean entries are still queued behind a flagged one. A second hard case is when one cycle both removes a flagged entry and adds a clean one. The bench places a flagged character ahead of clean ones, pops only the flagged one, and checks that bit 7 drops while the level stays non-zero. It then drives a push and a pop in the same cycle in both flag combinations. It also fills the queue to 16 and pushes once more to bring about the overrun. It drains the queue afterwards to prove the extra character was never stored.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } rxq_entry_t;

  function automatic logic entry_has_err(rxq_entry_t e);
    return e.brk | e.frm | e.par;
  endfunction
endpackage

// File: rtl/rxq_storage.sv
module rxq_storage
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  rxq_entry_t       push_entry_i,
  input  logic             pop_i,
  output rxq_entry_t       head_o,
  output logic             push_ok_o,
  output logic             pop_ok_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [LVL_W-1:0] level_o
);
  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

  rxq_entry_t       mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [LVL_W-1:0] lvl_q;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o   = (lvl_q == '0);
  assign full_o    = (lvl_q == DEPTH_L);
  assign pop_ok_o  = pop_i & ~empty_o;
  // a pop in the same cycle frees the slot a full queue needs
  assign push_ok_o = push_i & (~full_o | pop_ok_o);
  assign head_o    = empty_o ? '0 : mem_q[rptr_q];
  assign level_o   = lvl_q;

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem_q[wptr_q] <= push_entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      if (push_ok_o) wptr_q <= ptr_next(wptr_q);
      if (pop_ok_o)  rptr_q <= ptr_next(rptr_q);
      case ({push_ok_o, pop_ok_o})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  a_r2_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= DEPTH_L);
  a_r2_level_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_ok_o && !pop_ok_o) |=> (lvl_q == $past(lvl_q) + 1'b1));
  a_r7_both_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_ok_o && pop_ok_o) |=> $stable(lvl_q));
  a_r8_empty_no_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !push_i) |=> (empty_o && $stable(rptr_q)));
endmodule

// File: rtl/rxq_err_track.sv
module rxq_err_track #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             add_err_i,
  input  logic             del_err_i,
  input  logic [CNT_W-1:0] level_i,
  output logic             any_err_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      case ({add_err_i, del_err_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign any_err_o = (cnt_q != '0);

  a_r5_cnt_le_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= level_i);
  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (del_err_i && !add_err_i) |-> (cnt_q != '0));
endmodule

// File: rtl/uart_rx_err_fifo.sv
module uart_rx_err_fifo
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [7:0]       wr_data_i,
  input  logic             wr_brk_i,
  input  logic             wr_frm_i,
  input  logic             wr_par_i,
  input  logic             rd_data_i,
  output logic [7:0]       rd_data_o,
  input  logic             rd_stat_i,
  output logic [7:0]       stat_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [LVL_W-1:0] level_o
);
  rxq_entry_t in_e, head;
  logic push_ok, pop_ok, any_err, ovr_q;

  assign in_e = '{brk: wr_brk_i, frm: wr_frm_i, par: wr_par_i, data: wr_data_i};

  rxq_storage #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .push_i(wr_valid_i), .push_entry_i(in_e), .pop_i(rd_data_i),
    .head_o(head), .push_ok_o(push_ok), .pop_ok_o(pop_ok),
    .full_o, .empty_o, .level_o
  );

  rxq_err_track #(.DEPTH(DEPTH)) u_err (
    .clk_i, .rst_ni,
    .add_err_i(push_ok & entry_has_err(in_e)),
    .del_err_i(pop_ok & entry_has_err(head)),
    .level_i(level_o),
    .any_err_o(any_err)
  );

  // new overrun wins over a clearing status read in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ovr_q <= 1'b0;
    else if (wr_valid_i && !push_ok) ovr_q <= 1'b1;
    else if (rd_stat_i)            ovr_q <= 1'b0;
  end

  assign rd_data_o = head.data;
  assign stat_o = {any_err, 1'b0, full_o, head.brk, head.frm, head.par, ovr_q, ~empty_o};

  a_r4_stat_no_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && !rd_data_i && !wr_valid_i) |=> $stable(level_o));
  a_r5_empty_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !any_err);
  a_r6_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && full_o && !rd_data_i) |=> (ovr_q && full_o));
  a_r8_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (rd_data_o == 8'h00));
  a_r9_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({full_o, empty_o}));
endmodule

// File: tb/uart_rx_err_fifo_test.sv
module uart_rx_err_fifo_test;
  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_brk = 0, wr_frm = 0, wr_par = 0, rd_d = 0, rd_s = 0;
  logic [7:0] wr_data = 0, rd_data, stat;
  logic full, empty;
  logic [4:0] level;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_rx_err_fifo uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .wr_brk_i(wr_brk), .wr_frm_i(wr_frm), .wr_par_i(wr_par),
    .rd_data_i(rd_d), .rd_data_o(rd_data), .rd_stat_i(rd_s), .stat_o(stat),
    .full_o(full), .empty_o(empty), .level_o(level)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock cycle; err = {brk,frm,par}
  task automatic cyc(bit w, logic [7:0] d, logic [2:0] err, bit pop, bit sr);
    wr_valid = w; wr_data = d; {wr_brk, wr_frm, wr_par} = err; rd_d = pop; rd_s = sr;
    @(posedge clk); #1;
    wr_valid = 0; rd_d = 0; rd_s = 0; {wr_brk, wr_frm, wr_par} = 0;
  endtask

  task automatic t_reset;
    chk("R1 level", level, 0); chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);   chk("R1 stat", stat, 8'h00);
    chk("R8 empty data", rd_data, 0);
  endtask

  task automatic t_order;
    cyc(1, 8'h11, 0, 0, 0); cyc(1, 8'h22, 0, 0, 0); cyc(1, 8'h33, 0, 0, 0);
    chk("R2 level3", level, 3); chk("R9 ready", stat[0], 1); chk("R9 bit6", stat[6], 0);
    chk("R2 head0", rd_data, 8'h11); cyc(0, 0, 0, 1, 0);
    chk("R2 head1", rd_data, 8'h22); cyc(0, 0, 0, 1, 0);
    chk("R2 head2", rd_data, 8'h33); cyc(0, 0, 0, 1, 0);
    chk("R2 drained", level, 0); chk("R9 not ready", stat[0], 0);
  endtask

  task automatic t_head_err;
    cyc(1, 8'hA0, 3'b000, 0, 0); cyc(1, 8'hB0, 3'b001, 0, 0); cyc(1, 8'hC0, 3'b110, 0, 0);
    chk("R5 any set", stat[7], 1); chk("R3 head clean", stat[4:2], 0);
    cyc(0, 0, 0, 0, 1);
    chk("R4 level kept", level, 3); chk("R4 head kept", rd_data, 8'hA0);
    cyc(0, 0, 0, 1, 0);
    chk("R3 par", stat[4:2], 3'b001); chk("R3 data B", rd_data, 8'hB0);
    cyc(0, 0, 0, 0, 1);
    chk("R4 flags kept", stat[4:2], 3'b001); chk("R4 level kept2", level, 2);
    cyc(0, 0, 0, 1, 0);
    chk("R3 brk frm", stat[4:2], 3'b110); chk("R5 still set", stat[7], 1);
    cyc(0, 0, 0, 1, 0);
    chk("R5 cleared", stat[7], 0); chk("R3 empty flags", stat[4:2], 0);
  endtask

  task automatic t_summary;
    cyc(1, 8'h01, 3'b100, 0, 0); cyc(1, 8'h02, 0, 0, 0); cyc(1, 8'h03, 0, 0, 0);
    chk("R5 set", stat[7], 1);
    cyc(0, 0, 0, 1, 0);
    chk("R5 drop with clean left", stat[7], 0); chk("R5 level", level, 2);
    cyc(0, 0, 0, 1, 0); cyc(0, 0, 0, 1, 0);
  endtask

  task automatic t_overrun;
    for (int i = 0; i < 16; i++) cyc(1, 8'(i), 0, 0, 0);
    chk("R9 full", full, 1); chk("R9 bit5", stat[5], 1); chk("R6 no ovr yet", stat[1], 0);
    cyc(1, 8'hEE, 3'b010, 0, 0);
    chk("R6 level kept", level, 16); chk("R6 ovr set", stat[1], 1);
    chk("R6 no err stored", stat[7], 0);
    cyc(0, 0, 0, 0, 0);
    chk("R6 sticky", stat[1], 1);
    cyc(0, 0, 0, 0, 1);
    chk("R6 cleared", stat[1], 0);
    for (int i = 0; i < 16; i++) begin
      chk("R6 drain", rd_data, 32'(i)); cyc(0, 0, 0, 1, 0);
    end
    chk("R6 empty after", empty, 1);
  endtask

  task automatic t_simul;
    cyc(1, 8'h50, 3'b001, 0, 0);
    cyc(1, 8'h51, 3'b000, 1, 0);
    chk("R7 level", level, 1); chk("R7 err gone", stat[7], 0); chk("R7 head", rd_data, 8'h51);
    cyc(1, 8'h52, 3'b100, 1, 0);
    chk("R7 level2", level, 1); chk("R7 err new", stat[7], 1); chk("R7 head brk", stat[4], 1);
    for (int i = 0; i < 15; i++) cyc(1, 8'h60, 0, 0, 0);
    cyc(1, 8'h70, 0, 1, 0);
    chk("R7 full swap", level, 16); chk("R7 no ovr", stat[1], 0); chk("R7 err popped", stat[7], 0);
    for (int i = 0; i < 16; i++) cyc(0, 0, 0, 1, 0);
  endtask

  task automatic t_empty_read;
    chk("R8 data zero", rd_data, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R8 level", level, 0); chk("R8 still empty", empty, 1);
    cyc(1, 8'h9C, 0, 0, 0);
    chk("R8 next pushed", rd_data, 8'h9C); chk("R8 level1", level, 1);
    cyc(0, 0, 0, 1, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #35 rst_n = 1;
    @(posedge clk); #1;
    t_reset; t_order; t_head_err; t_summary; t_overrun; t_simul; t_empty_read;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule